// File: doc/BRIEF.md
# Digital Steering Guard-Time Validator

This block stands in for the analog RC steering network that follows a tone-pair decoder. It watches the decoder's early-steering flag and its 4-bit code. A tone is registered only after the signal condition has lasted a programmable tone-present guard time. The block then holds the registration through the inter-digit pause, and releases it only after a separate tone-absent guard time. Dropouts shorter than that window are bridged, so they never produce a second registration.

On registration the code is written into a receive data register and a guard-time output goes high. After a fixed settling delay a delayed-steering flag follows. That rising edge sets an interrupt-pending flag. The active-low interrupt output shows this flag when interrupt mode is enabled. A status-read strobe clears the pending flag. Both guard times are counted in ticks of `TICK_DIV` clock cycles. The tick prescaler restarts together with the guard counter, so every guard window is an exact number of cycles.

Top module: `steer_guard_validator`

## Requirements
- R1: With tone-present setting N (N=0 acts as 1), a tone is registered on the (N*TICK_DIV+1)-th consecutive clock edge at which `est_i` is sampled high, starting from the idle state. Any low sample before that restarts the count.
- R2: At registration, `code_i` is copied into `rx_data_o`. `rx_data_o` keeps its value at all other times, even while `code_i` changes.
- R3: `gt_o` is high from the registration edge for as long as `est_i` stays high. It goes low on the first edge at which `est_i` is sampled low.
- R4: `dstd_o` rises exactly SETTLE (2) clock edges after the edge that updated `rx_data_o`.
- R5: With tone-absent setting M (M=0 acts as 1), the registration is released on the (M*TICK_DIV+1)-th consecutive low sample of `est_i`, and `dstd_o` falls SETTLE edges later. A shorter run of low samples is bridged: `dstd_o` stays high and `gt_o` returns on the first high sample.
- R6: While a registration is held, including across a bridged dropout, no new code is latched. A new tone can only be registered after the pause has been validated.
- R7: `status_o[0]` equals `dstd_o` and `status_o[1]` is the interrupt-pending flag.
- R8: The pending flag is set when `dstd_o` rises. `irq_no` is low exactly when the pending flag is set and `irq_en_i` is high.
- R9: A high `stat_rd_i` at a clock edge clears the pending flag and leaves `dstd_o` unchanged. The pending flag also clears when `dstd_o` falls.
- R10: After reset `rx_data_o`=0, `gt_o`=0, `dstd_o`=0, `status_o`=0 and `irq_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| est_i | input | 1 | Early-steering flag from the tone decoder |
| code_i | input | CODE_W | Decoded tone code |
| present_gt_i | input | GT_W | Tone-present guard time in ticks |
| absent_gt_i | input | GT_W | Tone-absent guard time in ticks |
| irq_en_i | input | 1 | Interrupt mode enable |
| stat_rd_i | input | 1 | Status-read strobe, clears pending interrupt |
| rx_data_o | output | CODE_W | Receive data register |
| gt_o | output | 1 | Guard-time output |
| dstd_o | output | 1 | Delayed-steering flag |
| status_o | output | 2 | {interrupt pending, delayed steering} |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with TICK_DIV=2, GT_W=3 and SETTLE=2. At these values every guard window is a few cycles long. This makes it possible to sweep the tone-present setting over 0 to 3 and the tone-absent setting over 1 to 3, cycle by cycle. For each pair the bench applies four stimuli: a tone one edge too short, a valid tone, a dropout exactly one edge short of a valid pause, and a validated pause. The interrupt enable and the status read alternate across the sweep. This exercises both ways the pending flag can clear, and the masked and unmasked interrupt output.

// File: rtl/sgv_pkg.sv
package sgv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUAL  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_PAUSE = 2'd3
  } steer_state_e;
endpackage

// File: rtl/sgv_guard_timer.sv
module sgv_guard_timer #(
  parameter int TICK_DIV = 1000,
  parameter int GT_W     = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [GT_W-1:0] limit_i,
  output logic            expire_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic            tick;
  logic [GT_W-1:0] cnt_q;
  logic [GT_W-1:0] lim_eff;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pre_q <= '0;
        else if (!run_i || tick) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  // zero setting behaves as one tick
  assign lim_eff  = (limit_i == '0) ? GT_W'(1) : limit_i;
  assign expire_o = run_i & tick & (cnt_q == lim_eff - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sgv_steer_fsm.sv
module sgv_steer_fsm
  import sgv_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              est_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              expire_i,
  output logic              run_o,
  output logic              pause_sel_o,
  output logic              gt_o,
  output logic              steer_o,
  output logic [CODE_W-1:0] rx_data_o
);
  steer_state_e state_q, state_d;
  logic         latch;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (est_i) state_d = ST_QUAL;
      ST_QUAL:  if (!est_i) state_d = ST_IDLE;
                else if (expire_i) state_d = ST_HOLD;
      ST_HOLD:  if (!est_i) state_d = ST_PAUSE;
      ST_PAUSE: if (est_i) state_d = ST_HOLD;
                else if (expire_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign latch       = (state_q == ST_QUAL) & est_i & expire_i;
  assign run_o       = ((state_q == ST_QUAL) & est_i) | ((state_q == ST_PAUSE) & ~est_i);
  assign pause_sel_o = (state_q == ST_PAUSE);
  assign gt_o        = (state_q == ST_HOLD);
  assign steer_o     = (state_q == ST_HOLD) | (state_q == ST_PAUSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rx_data_o <= '0;
    end else begin
      state_q <= state_d;
      if (latch) rx_data_o <= code_i;
    end
  end
endmodule

// File: rtl/sgv_settle_irq.sv
module sgv_settle_irq #(
  parameter int SETTLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic steer_i,
  input  logic rd_i,
  output logic dstd_o,
  output logic pend_o
);
  logic [SETTLE-1:0] sh_q;
  logic [SETTLE:0]   tap;
  logic              rise, fall;

  assign tap[0]        = steer_i;
  assign tap[SETTLE:1] = sh_q;
  assign dstd_o        = tap[SETTLE];
  assign rise          = tap[SETTLE-1] & ~tap[SETTLE];
  assign fall          = ~tap[SETTLE-1] & tap[SETTLE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      pend_o <= 1'b0;
    end else begin
      sh_q <= tap[SETTLE-1:0];
      if (rise)             pend_o <= 1'b1;
      else if (rd_i || fall) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/steer_guard_validator.sv
module steer_guard_validator #(
  parameter int TICK_DIV = 1000,
  parameter int GT_W     = 8,
  parameter int CODE_W   = 4,
  parameter int SETTLE   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              est_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [GT_W-1:0]   present_gt_i,
  input  logic [GT_W-1:0]   absent_gt_i,
  input  logic              irq_en_i,
  input  logic              stat_rd_i,
  output logic [CODE_W-1:0] rx_data_o,
  output logic              gt_o,
  output logic              dstd_o,
  output logic [1:0]        status_o,
  output logic              irq_no
);
  logic            run, pause_sel, expire, steer, pend;
  logic [GT_W-1:0] limit;

  assign limit = pause_sel ? absent_gt_i : present_gt_i;

  sgv_guard_timer #(.TICK_DIV(TICK_DIV), .GT_W(GT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .limit_i  (limit),
    .expire_o (expire)
  );

  sgv_steer_fsm #(.CODE_W(CODE_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .est_i       (est_i),
    .code_i      (code_i),
    .expire_i    (expire),
    .run_o       (run),
    .pause_sel_o (pause_sel),
    .gt_o        (gt_o),
    .steer_o     (steer),
    .rx_data_o   (rx_data_o)
  );

  sgv_settle_irq #(.SETTLE(SETTLE)) i_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .steer_i (steer),
    .rd_i    (stat_rd_i),
    .dstd_o  (dstd_o),
    .pend_o  (pend)
  );

  assign status_o = {pend, dstd_o};
  assign irq_no   = ~(pend & irq_en_i);
endmodule

// File: rtl/sgv_checker.sv
module sgv_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              est_i,
  input logic              irq_en_i,
  input logic              stat_rd_i,
  input logic [CODE_W-1:0] rx_data_o,
  input logic              gt_o,
  input logic              dstd_o,
  input logic              irq_no
);
  AST_GT_NEEDS_EST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gt_o) |-> $past(est_i)); // R1
  AST_LATCH_AT_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> $rose(gt_o)); // R2
  AST_GT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gt_o && !est_i) |=> !gt_o); // R3
  AST_SETTLED_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dstd_o) |-> $stable(rx_data_o)); // R4
  AST_IRQ_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (dstd_o && irq_en_i)); // R8
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && dstd_o) |=> irq_no); // R9
endmodule

bind steer_guard_validator sgv_checker #(.CODE_W(CODE_W)) i_sgv_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .est_i     (est_i),
  .irq_en_i  (irq_en_i),
  .stat_rd_i (stat_rd_i),
  .rx_data_o (rx_data_o),
  .gt_o      (gt_o),
  .dstd_o    (dstd_o),
  .irq_no    (irq_no)
);

// File: tb/test_steer_guard_validator.sv
module test_steer_guard_validator;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int GTW        = 3;
  localparam int CW         = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          est;
  logic [CW-1:0] code;
  logic [GTW-1:0] pgt, agt;
  logic          irq_en, rd;
  logic [CW-1:0] rx;
  logic          gt, dstd, irq_n;
  logic [1:0]    status;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  steer_guard_validator #(.TICK_DIV(DIV), .GT_W(GTW), .CODE_W(CW), .SETTLE(2)) i_steer_guard_validator (
    .clk_i(clk), .rst_ni(rst_n), .est_i(est), .code_i(code),
    .present_gt_i(pgt), .absent_gt_i(agt), .irq_en_i(irq_en), .stat_rd_i(rd),
    .rx_data_o(rx), .gt_o(gt), .dstd_o(dstd), .status_o(status), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  logic [CW-1:0] exp_rx;

  initial begin
    est = 0; code = '0; pgt = '0; agt = 3'd1; irq_en = 0; rd = 0; rst_n = 0;
    repeat (3) cyc();
    // R10 reset state
    chk("R10 rx", 8'(rx), 8'h0);
    chk("R10 gt", 8'(gt), 8'h0);
    chk("R10 dstd", 8'(dstd), 8'h0);
    chk("R10 status", 8'(status), 8'h0);
    chk("R10 irq", 8'(irq_n), 8'h1);
    rst_n = 1;
    exp_rx = '0;
    for (int n = 0; n <= 3; n++) begin
      for (int m = 1; m <= 3; m++) begin
        int neff;
        int pres;
        int abs_w;
        bit do_rd;
        logic [CW-1:0] c;
        neff  = (n == 0) ? 1 : n;
        pres  = neff * DIV;
        abs_w = m * DIV;
        do_rd = (n % 2) == 0;
        c     = CW'(n * 5 + m * 3 + 1);
        pgt = GTW'(n); agt = GTW'(m); irq_en = ((n + m) % 2) == 1;
        est = 0;
        repeat (abs_w + 6) cyc();
        // R1 one edge too short
        code = ~c; est = 1;
        for (int h = 1; h <= pres; h++) begin
          cyc();
          chk("R1 short gt", 8'(gt), 8'h0);
          chk("R2 short rx", 8'(rx), 8'(exp_rx));
        end
        est = 0;
        repeat (2) cyc();
        chk("R1 short dstd", 8'(dstd), 8'h0);
        // valid tone
        code = c; est = 1;
        for (int h = 1; h <= pres + 6; h++) begin
          bit rg, ds;
          cyc();
          rg = h >= pres + 1;
          ds = h >= pres + 3;
          if (h == pres + 1) begin
            exp_rx = c;
            code = ~c; // R2 later code changes must not land
          end
          chk("R1/R3 gt", 8'(gt), 8'(rg));
          chk("R2 rx", 8'(rx), 8'(rg ? c : exp_rx));
          chk("R4 dstd", 8'(dstd), 8'(ds));
          chk("R7 status", 8'(status), 8'({ds, ds}));
          chk("R8 irq", 8'(irq_n), 8'(!(ds && irq_en)));
        end
        // R5 dropout one edge short of a valid pause
        est = 0;
        for (int l = 1; l <= abs_w; l++) begin
          cyc();
          chk("R3 gt low", 8'(gt), 8'h0);
          chk("R5 bridged dstd", 8'(dstd), 8'h1);
        end
        code = c ^ 4'h5; est = 1;
        for (int h = 1; h <= 3; h++) begin
          cyc();
          chk("R5 gt back", 8'(gt), 8'h1);
          chk("R6 no relatch", 8'(rx), 8'(exp_rx));
        end
        if (do_rd) begin
          rd = 1;
          cyc();
          rd = 0;
          chk("R9 rd irq", 8'(irq_n), 8'h1);
          chk("R9 rd dstd", 8'(dstd), 8'h1);
          chk("R7 status rd", 8'(status), 8'h1);
        end
        // validated pause
        est = 0;
        for (int l = 1; l <= abs_w + 4; l++) begin
          bit ds;
          cyc();
          ds = l < abs_w + 3;
          chk("R5 pause dstd", 8'(dstd), 8'(ds));
          chk("R3 pause gt", 8'(gt), 8'h0);
          chk("R9 irq", 8'(irq_n), 8'(!(ds && irq_en && !do_rd)));
          chk("R7 pend", 8'(status[1]), 8'(ds && !do_rd));
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule